// File: doc/BRIEF.md
# Flash Embedded Operation Sequencer

This block is the control logic of a byte-wide NOR flash device with a 22-bit address space and 64 equal sectors. It watches bus writes for unlock-prefixed command sequences and turns them into byte program, sector erase, chip erase, erase suspend and erase resume operations. Program and erase run as timed phases from an internal counter. An erase first preprograms each chosen sector to 0x00 and then erases it to 0xFF.

A 16-bit protection mask marks groups of four adjacent sectors as locked. A locked group can be neither programmed nor erased. While an operation runs, the ready output is low and reads return a status byte instead of array data. On that byte, bit 7 is a data-polling bit and bit 6 changes on every read. When the operation ends, or when the reset input is pulled low, the block returns to plain read mode.

The array is a small register store with a few bytes per sector. The byte inside a sector is picked by the lowest address bits.

Top module: `flash_seq_top`

## Requirements
- R1: The sector index is address bits 21..16 and the group index is sector bits 5..2. A program aimed at a group whose `prot_i` bit is 1 is dropped: `ready_o` stays high and the byte is unchanged.
- R2: The program sequence is 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then one data write at the target. Only address bits 10..0 are compared. The stored byte becomes old AND new. `ready_o` is low for exactly PROG_CYCLES cycles after the data write.
- R3: A write that does not match the next expected step of a sequence returns the decoder to read mode. A following command needs the full unlock again.
- R4: While busy, a read returns bit 7 as the complement of the programmed bit 7 during a program, and as 0 during an erase. Once finished, reads return true data.
- R5: While busy, bit 6 of the read data inverts after each read strobe.
- R6: `ready_o` is high after reset, in read mode and during suspend. It is low during program, during the erase collection window and during erase.
- R7: Sector erase is two unlock pairs around 0x80 at 0x555, then 0x30 at a sector address. More bare 0x30 writes within WIN_CYCLES add sectors. Each selected unprotected sector ends at 0xFF. Other sectors are untouched.
- R8: Chip erase replaces the final 0x30 with 0x10 at 0x555. It erases every unprotected sector and leaves protected groups unchanged.
- R9: If every selected sector is protected, the block returns to ready when the window closes, and no data changes.
- R10: Writing 0xB0 during an erase suspends it: `ready_o` goes high and erase progress holds for any length of time. Reads of unmarked sectors return data. Reads of marked sectors return a status byte with bit 7 = 1 and a steady bit 6. Writing 0x30 resumes the erase.
- R11: During suspend, a program to an unmarked unprotected sector runs and then returns to suspend. A program to a marked sector is dropped.
- R12: Pulling `rst_ni` low aborts any operation. After release the block is ready in read mode and accepts new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, aborts operations |
| addr_i | input | 22 | Byte address for writes and reads |
| wdata_i | input | 8 | Write data / command byte |
| we_i | input | 1 | Single-cycle write strobe |
| re_i | input | 1 | Read strobe, advances the toggle bit |
| prot_i | input | 16 | Per-group protection mask, 1 = locked |
| rdata_o | output | 8 | Array data or status byte |
| ready_o | output | 1 | High when no program or erase is running |

## Verification
On every cycle, the assertions check four things: array writes and sector fills never touch a locked group, a program during suspend never lands in a sector marked for erase, the erase set is frozen while suspended, and ready falls only after a bus write. Toggle behaviour on busy reads is also checked cycle by cycle. The bench scenarios cover the rest: the stored values after program and erase, the exact busy length, abandoned sequences, multi-sector collection, the all-protected early exit, suspend with nested program, and reset abort.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    M_READ, M_PROG, M_WIN, M_ERASE, M_SUSP, M_SPROG
  } mode_e;

  typedef enum logic [2:0] {
    C_IDLE, C_UL1, C_UL2, C_EXT, C_EUL1, C_EUL2, C_PDATA
  } cstate_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          prog_req_o,
  output logic          sect_req_o,
  output logic          chip_req_o,
  output logic          susp_req_o,
  output logic          resume_req_o
);
  cstate_e st_q, st_d;
  logic a555, a2aa, listen;

  assign a555   = addr_i[10:0] == 11'h555;
  assign a2aa   = addr_i[10:0] == 11'h2AA;
  assign listen = (mode_i == M_READ) || (mode_i == M_SUSP);

  always_comb begin
    st_d         = st_q;
    prog_req_o   = 1'b0;
    sect_req_o   = 1'b0;
    chip_req_o   = 1'b0;
    susp_req_o   = 1'b0;
    resume_req_o = 1'b0;
    if (we_i) begin
      if (mode_i == M_WIN) begin
        sect_req_o = data_i == 8'h30;
      end else if (mode_i == M_ERASE) begin
        susp_req_o = data_i == 8'hB0;
      end else if (listen) begin
        if (mode_i == M_SUSP && st_q == C_IDLE && data_i == 8'h30) begin
          resume_req_o = 1'b1;
        end else begin
          st_d = C_IDLE;
          case (st_q)
            C_IDLE: if (a555 && data_i == 8'hAA) st_d = C_UL1;
            C_UL1:  if (a2aa && data_i == 8'h55) st_d = C_UL2;
            C_UL2: begin
              if (a555 && data_i == 8'hA0) st_d = C_PDATA;
              else if (a555 && data_i == 8'h80 && mode_i == M_READ) st_d = C_EXT;
            end
            C_EXT:  if (a555 && data_i == 8'hAA) st_d = C_EUL1;
            C_EUL1: if (a2aa && data_i == 8'h55) st_d = C_EUL2;
            C_EUL2: begin
              if (data_i == 8'h30) sect_req_o = 1'b1;
              else if (a555 && data_i == 8'h10) chip_req_o = 1'b1;
            end
            C_PDATA: prog_req_o = 1'b1;
            default: st_d = C_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= C_IDLE;
    else if (!listen) st_q <= C_IDLE;
    else             st_q <= st_d;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NSECT = 64,
  parameter int WPS   = 4
) (
  input  logic                     clk_i,
  input  logic [$clog2(NSECT)-1:0] rd_sect_i,
  input  logic [$clog2(WPS)-1:0]   rd_off_i,
  output logic [7:0]               rd_data_o,
  input  logic                     wr_en_i,
  input  logic [$clog2(NSECT)-1:0] wr_sect_i,
  input  logic [$clog2(WPS)-1:0]   wr_off_i,
  input  logic [7:0]               wr_data_i,
  input  logic                     fill_en_i,
  input  logic [$clog2(NSECT)-1:0] fill_sect_i,
  input  logic [7:0]               fill_val_i
);
  localparam int SW    = $clog2(NSECT);
  localparam int WB    = $clog2(WPS);
  localparam int DEPTH = NSECT * WPS;

  logic [7:0] mem [DEPTH];

  assign rd_data_o = mem[{rd_sect_i, rd_off_i}];

  // Cells only move toward 0 on program; a fill sets a whole sector.
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      for (int w = 0; w < WPS; w++) mem[{fill_sect_i, WB'(w)}] <= fill_val_i;
    end else if (wr_en_i) begin
      mem[{wr_sect_i, wr_off_i}] <= mem[{wr_sect_i, wr_off_i}] & wr_data_i;
    end
  end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_seq_pkg::*;
#(
  parameter int AW          = 22,
  parameter int NSECT       = 64,
  parameter int NGRP        = 16,
  parameter int WPS         = 4,
  parameter int PROG_CYCLES = 8,
  parameter int PRE_CYCLES  = 6,
  parameter int ERS_CYCLES  = 10,
  parameter int WIN_CYCLES  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prog_req_i,
  input  logic                     sect_req_i,
  input  logic                     chip_req_i,
  input  logic                     susp_req_i,
  input  logic                     resume_req_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [7:0]               data_i,
  input  logic [NGRP-1:0]          prot_i,
  output mode_e                    mode_o,
  output logic [NSECT-1:0]         erase_set_o,
  output logic                     prog_bit7_o,
  output logic                     wr_en_o,
  output logic [$clog2(NSECT)-1:0] wr_sect_o,
  output logic [$clog2(WPS)-1:0]   wr_off_o,
  output logic [7:0]               wr_data_o,
  output logic                     fill_en_o,
  output logic [$clog2(NSECT)-1:0] fill_sect_o,
  output logic [7:0]               fill_val_o
);
  localparam int SW   = $clog2(NSECT);
  localparam int WB   = $clog2(WPS);
  localparam int GPS  = NSECT / NGRP;
  localparam int MA   = PROG_CYCLES > PRE_CYCLES ? PROG_CYCLES : PRE_CYCLES;
  localparam int MB   = ERS_CYCLES > WIN_CYCLES ? ERS_CYCLES : WIN_CYCLES;
  localparam int MAXC = MA > MB ? MA : MB;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_SCAN, PH_PRE, PH_ERS} phase_e;

  mode_e            mode_q;
  phase_e           ph_q;
  logic [CW-1:0]    cnt_q;
  logic [SW-1:0]    cur_q, p_sect_q, req_sect;
  logic [WB-1:0]    p_off_q, req_off;
  logic [7:0]       p_data_q;
  logic [NSECT-1:0] set_q, prot_sect, req_bit, win_next, win_masked;
  logic             cnt_zero;

  for (genvar s = 0; s < NSECT; s++) begin : g_prot
    assign prot_sect[s] = prot_i[s / GPS];
  end

  assign req_sect   = addr_i[AW-1 -: SW];
  assign req_off    = addr_i[WB-1:0];
  assign req_bit    = {{(NSECT-1){1'b0}}, 1'b1} << req_sect;
  assign win_next   = set_q | (sect_req_i ? req_bit : '0);
  assign win_masked = win_next & ~prot_sect;
  assign cnt_zero   = cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_READ;
      ph_q     <= PH_SCAN;
      cnt_q    <= '0;
      cur_q    <= '0;
      p_sect_q <= '0;
      p_off_q  <= '0;
      p_data_q <= '0;
      set_q    <= '0;
    end else begin
      case (mode_q)
        M_READ: begin
          if (prog_req_i && !prot_sect[req_sect]) begin
            mode_q   <= M_PROG;
            p_sect_q <= req_sect;
            p_off_q  <= req_off;
            p_data_q <= data_i;
            cnt_q    <= CW'(PROG_CYCLES - 1);
          end else if (sect_req_i) begin
            mode_q <= M_WIN;
            set_q  <= req_bit;
            cnt_q  <= CW'(WIN_CYCLES - 1);
          end else if (chip_req_i && |(~prot_sect)) begin
            mode_q <= M_ERASE;
            set_q  <= ~prot_sect;
            ph_q   <= PH_SCAN;
            cur_q  <= '0;
          end
        end
        M_PROG, M_SPROG: begin
          if (cnt_zero) mode_q <= (mode_q == M_PROG) ? M_READ : M_SUSP;
          else          cnt_q  <= cnt_q - 1'b1;
        end
        M_WIN: begin
          if (cnt_zero) begin
            set_q  <= win_masked;
            mode_q <= (|win_masked) ? M_ERASE : M_READ;
            ph_q   <= PH_SCAN;
            cur_q  <= '0;
          end else begin
            set_q <= win_next;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        M_ERASE: begin
          if (susp_req_i) begin
            mode_q <= M_SUSP;
          end else begin
            case (ph_q)
              PH_SCAN: begin
                if (set_q == '0) mode_q <= M_READ;
                else if (set_q[cur_q]) begin
                  ph_q  <= PH_PRE;
                  cnt_q <= CW'(PRE_CYCLES - 1);
                end else cur_q <= cur_q + 1'b1;
              end
              PH_PRE: begin
                if (cnt_zero) begin
                  ph_q  <= PH_ERS;
                  cnt_q <= CW'(ERS_CYCLES - 1);
                end else cnt_q <= cnt_q - 1'b1;
              end
              default: begin
                if (cnt_zero) begin
                  set_q[cur_q] <= 1'b0;
                  cur_q        <= cur_q + 1'b1;
                  ph_q         <= PH_SCAN;
                end else cnt_q <= cnt_q - 1'b1;
              end
            endcase
          end
        end
        M_SUSP: begin
          if (resume_req_i) begin
            mode_q <= M_ERASE;
          end else if (prog_req_i && !prot_sect[req_sect] && !set_q[req_sect]) begin
            mode_q   <= M_SPROG;
            p_sect_q <= req_sect;
            p_off_q  <= req_off;
            p_data_q <= data_i;
            cnt_q    <= CW'(PROG_CYCLES - 1);
          end
        end
        default: mode_q <= M_READ;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign erase_set_o = set_q;
  assign prog_bit7_o = p_data_q[7];
  assign wr_en_o     = (mode_q == M_PROG || mode_q == M_SPROG) && cnt_zero;
  assign wr_sect_o   = p_sect_q;
  assign wr_off_o    = p_off_q;
  assign wr_data_o   = p_data_q;
  assign fill_en_o   = (mode_q == M_ERASE) && (ph_q != PH_SCAN) && cnt_zero && !susp_req_i;
  assign fill_sect_o = cur_q;
  assign fill_val_o  = (ph_q == PH_PRE) ? 8'h00 : 8'hFF;
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int AW          = 22,
  parameter int NSECT       = 64,
  parameter int NGRP        = 16,
  parameter int WPS         = 4,
  parameter int PROG_CYCLES = 8,
  parameter int PRE_CYCLES  = 6,
  parameter int ERS_CYCLES  = 10,
  parameter int WIN_CYCLES  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [NGRP-1:0] prot_i,
  output logic [7:0]      rdata_o,
  output logic            ready_o
);
  localparam int SW = $clog2(NSECT);
  localparam int WB = $clog2(WPS);

  mode_e            mode;
  logic             prog_req, sect_req, chip_req, susp_req, resume_req;
  logic [NSECT-1:0] erase_set;
  logic             prog_bit7, wr_en, fill_en;
  logic [SW-1:0]    wr_sect, fill_sect, rd_sect;
  logic [WB-1:0]    wr_off;
  logic [7:0]       wr_data, fill_val, arr_data;
  logic             busy, susp_hit, status_rd, tog_q, dq7;

  flash_cmd_decode #(.AW(AW)) u_dec (
    .clk_i, .rst_ni, .mode_i(mode), .we_i, .addr_i, .data_i(wdata_i),
    .prog_req_o(prog_req), .sect_req_o(sect_req), .chip_req_o(chip_req),
    .susp_req_o(susp_req), .resume_req_o(resume_req)
  );

  flash_op_engine #(
    .AW(AW), .NSECT(NSECT), .NGRP(NGRP), .WPS(WPS), .PROG_CYCLES(PROG_CYCLES),
    .PRE_CYCLES(PRE_CYCLES), .ERS_CYCLES(ERS_CYCLES), .WIN_CYCLES(WIN_CYCLES)
  ) u_eng (
    .clk_i, .rst_ni, .prog_req_i(prog_req), .sect_req_i(sect_req),
    .chip_req_i(chip_req), .susp_req_i(susp_req), .resume_req_i(resume_req),
    .addr_i, .data_i(wdata_i), .prot_i,
    .mode_o(mode), .erase_set_o(erase_set), .prog_bit7_o(prog_bit7),
    .wr_en_o(wr_en), .wr_sect_o(wr_sect), .wr_off_o(wr_off), .wr_data_o(wr_data),
    .fill_en_o(fill_en), .fill_sect_o(fill_sect), .fill_val_o(fill_val)
  );

  assign rd_sect = addr_i[AW-1 -: SW];

  flash_array #(.NSECT(NSECT), .WPS(WPS)) u_arr (
    .clk_i, .rd_sect_i(rd_sect), .rd_off_i(addr_i[WB-1:0]), .rd_data_o(arr_data),
    .wr_en_i(wr_en), .wr_sect_i(wr_sect), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .fill_en_i(fill_en), .fill_sect_i(fill_sect), .fill_val_i(fill_val)
  );

  assign busy      = mode inside {M_PROG, M_SPROG, M_WIN, M_ERASE};
  assign susp_hit  = (mode == M_SUSP) && erase_set[rd_sect];
  assign status_rd = busy || susp_hit;
  assign dq7       = susp_hit ? 1'b1 :
                     (mode == M_PROG || mode == M_SPROG) ? ~prog_bit7 : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tog_q <= 1'b0;
    else if (re_i && busy) tog_q <= ~tog_q;
  end

  assign rdata_o = status_rd ? {dq7, tog_q, 6'b0} : arr_data;
  assign ready_o = !busy;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker
  import flash_seq_pkg::*;
#(
  parameter int NSECT = 64,
  parameter int NGRP  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     we_i,
  input logic                     re_i,
  input logic [NGRP-1:0]          prot_i,
  input logic [7:0]               rdata_o,
  input logic                     ready_o,
  input logic                     busy_i,
  input mode_e                    mode_i,
  input logic [NSECT-1:0]         erase_set_i,
  input logic                     wr_en_i,
  input logic [$clog2(NSECT)-1:0] wr_sect_i,
  input logic                     fill_en_i,
  input logic [$clog2(NSECT)-1:0] fill_sect_i
);
  localparam int SW = $clog2(NSECT);
  localparam int GW = $clog2(NGRP);

  p_wr_unlocked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !prot_i[wr_sect_i[SW-1 -: GW]]);

  p_fill_unlocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> !prot_i[fill_sect_i[SW-1 -: GW]]);

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && busy_i) |=> (!busy_i || rdata_o[6] != $past(rdata_o[6])));

  p_busy_from_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(we_i));

  p_susp_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_SUSP && $past(mode_i == M_SUSP)) |-> $stable(erase_set_i));

  p_sprog_outside_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_i == M_SPROG) |-> !erase_set_i[wr_sect_i]);
endmodule

bind flash_seq_top flash_seq_checker #(.NSECT(NSECT), .NGRP(NGRP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .prot_i(prot_i),
  .rdata_o(rdata_o), .ready_o(ready_o), .busy_i(busy), .mode_i(mode),
  .erase_set_i(erase_set), .wr_en_i(wr_en), .wr_sect_i(wr_sect),
  .fill_en_i(fill_en), .fill_sect_i(fill_sect)
);

// File: tb/tb_flash_seq_top.sv
`timescale 1ns/1ps
module tb_flash_seq_top;
  localparam int PROG_CYCLES = 8;
  localparam int WIN_CYCLES  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] prot = '0;
  logic [7:0]  rdata;
  logic        ready;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  flash_seq_top #(.PROG_CYCLES(PROG_CYCLES), .WIN_CYCLES(WIN_CYCLES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .prot_i(prot), .rdata_o(rdata), .ready_o(ready)
  );

  function automatic logic [21:0] sa(int s, int o);
    return {s[5:0], 14'h0, o[1:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic unlock();
    wr(22'h555, 8'hAA); wr(22'h2AA, 8'h55);
  endtask

  task automatic prog(int s, int o, logic [7:0] d);
    unlock(); wr(22'h555, 8'hA0); wr(sa(s, o), d);
  endtask

  task automatic erase_pre();
    unlock(); wr(22'h555, 8'h80); unlock();
  endtask

  task automatic wait_ready(int lim, output int n);
    n = 0;
    while (!ready && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R6 ready after reset", ready, 1);
  endtask

  task automatic t_chip_erase();
    logic [7:0] d; int n;
    erase_pre(); wr(22'h555, 8'h10);
    check("R6 busy in chip erase", ready, 0);
    rd(sa(40, 0), d);
    check("R4 erase poll bit7", d[7], 0);
    wait_ready(5000, n);
    check("R8 chip erase ends", ready, 1);
    rd(sa(0, 1), d);  check("R8 sector0", d, 8'hFF);
    rd(sa(35, 3), d); check("R8 sector35", d, 8'hFF);
    rd(sa(63, 0), d); check("R8 sector63", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d, d2; int n;
    prog(3, 2, 8'hA5);
    rd(sa(3, 2), d); rd(sa(3, 2), d2);
    check("R4 program poll bit7", d[7], 0);
    check("R5 toggle differs", int'(d[6] ^ d2[6]), 1);
    wait_ready(100, n);
    rd(sa(3, 2), d); check("R4 true data after program", d, 8'hA5);
    prog(3, 2, 8'h0F);
    wait_ready(100, n);
    check("R2 busy length", n, PROG_CYCLES);
    rd(sa(3, 2), d); check("R2 AND merge", d, 8'h05);
  endtask

  task automatic t_bad_seq();
    logic [7:0] d;
    wr(22'h555, 8'hAA); wr(22'h2AA, 8'h12);
    wr(22'h555, 8'hA0); wr(sa(3, 3), 8'h00);
    check("R3 no busy after broken sequence", ready, 1);
    rd(sa(3, 3), d); check("R3 byte untouched", d, 8'hFF);
  endtask

  task automatic t_protect();
    logic [7:0] d; int n;
    prog(6, 0, 8'h00); wait_ready(100, n);
    prot = 16'h0002;
    prog(5, 0, 8'h12);
    check("R1 locked program stays ready", ready, 1);
    rd(sa(5, 0), d); check("R1 locked byte unchanged", d, 8'hFF);
    erase_pre(); wr(sa(6, 0), 8'h30);
    check("R6 busy in window", ready, 0);
    wait_ready(WIN_CYCLES + 5, n);
    check("R9 early return", ready, 1);
    rd(sa(6, 0), d); check("R9 locked sector unchanged", d, 8'h00);
  endtask

  task automatic t_sector_erase();
    logic [7:0] d; int n;
    prog(9, 0, 8'h11);  wait_ready(100, n);
    prog(20, 0, 8'h22); wait_ready(100, n);
    erase_pre(); wr(sa(3, 0), 8'h30);
    wr(sa(9, 0), 8'h30);
    wr(sa(6, 0), 8'h30);
    wait_ready(2000, n);
    rd(sa(3, 2), d);  check("R7 sector3 erased", d, 8'hFF);
    rd(sa(9, 0), d);  check("R7 added sector9 erased", d, 8'hFF);
    rd(sa(20, 0), d); check("R7 sector20 untouched", d, 8'h22);
    rd(sa(6, 0), d);  check("R1 locked sector6 kept", d, 8'h00);
  endtask

  task automatic t_suspend();
    logic [7:0] d, d2; int n;
    erase_pre(); wr(sa(20, 0), 8'h30);
    repeat (40) @(negedge clk);
    wr(sa(20, 0), 8'hB0);
    check("R10 ready in suspend", ready, 1);
    rd(sa(20, 0), d); rd(sa(20, 0), d2);
    check("R10 marked status bit7", d[7], 1);
    check("R10 bit6 steady", int'(d[6] ^ d2[6]), 0);
    rd(sa(3, 2), d); check("R10 unmarked read data", d, 8'hFF);
    repeat (100) @(negedge clk);
    rd(sa(20, 0), d); check("R10 still held", d[7], 1);
    prog(3, 0, 8'h5A);
    check("R11 program in suspend busy", ready, 0);
    wait_ready(100, n);
    rd(sa(3, 0), d);  check("R11 program in suspend data", d, 8'h5A);
    rd(sa(20, 1), d); check("R11 back to suspend", d[7], 1);
    prog(20, 1, 8'h00);
    check("R11 marked program dropped", ready, 1);
    wr(sa(0, 0), 8'h30);
    check("R10 resume busy", ready, 0);
    wait_ready(2000, n);
    rd(sa(20, 0), d); check("R10 erase completes", d, 8'hFF);
  endtask

  task automatic t_reset_abort();
    logic [7:0] d; int n;
    prot = '0;
    erase_pre(); wr(22'h555, 8'h10);
    repeat (30) @(negedge clk);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready after abort", ready, 1);
    repeat (20) @(negedge clk);
    check("R12 no resumption", ready, 1);
    prog(3, 1, 8'h77); wait_ready(100, n);
    rd(sa(3, 1), d); check("R12 new command works", d, 8'h77);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_bad_seq();
    t_protect();
    t_sector_erase();
    t_suspend();
    t_reset_abort();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end
endmodule